// File: doc/BRIEF.md
# Bus Master Security Gate

This block sits on the path between one bus master and a downstream memory port. It handles one access at a time. At acceptance it sends the request address to an external region-attribution lookup, which answers in the same cycle with two flags: "exempt" and "non-secure region". The gate combines these flags with the master's configured security state and picks one of four actions:

- forward the access tagged secure;
- forward it tagged non-secure;
- answer it locally as read-as-zero/write-ignored;
- answer it locally with an error.

Forwarded accesses keep their address, direction, size (1, 2, 4 or 8 bytes) and little-endian data unchanged; only the security attribute is added. An error-blocked access can raise a sticky violation interrupt. A level-sensitive clear input drops that interrupt, and while it is held high it also suppresses new violations.

Both sides use a valid/ready request channel and a valid/ready response channel. The action is fixed when the request is accepted, so configuration changes during a transaction cannot alter it.

Top module: `bus_master_sec_gate`

## Requirements
- R1: An accepted access whose lookup reports exempt is forwarded downstream. `dn_secure` (1 = secure, 0 = non-secure) is the inverse of `cfg_master_ns` sampled at acceptance.
- R2: An accepted access that is not exempt, in a region the lookup reports non-secure, is forwarded with `dn_secure` = 0 whatever the master configuration.
- R3: An accepted access to a secure region (both lookup flags low) with `cfg_master_ns` = 0 is forwarded with `dn_secure` = 1.
- R4: A secure-region access with `cfg_master_ns` = 1 and `cfg_err_resp` = 0 is not forwarded. The cycle after acceptance it is answered with `up_rsp_valid` = 1, `up_rsp_err` = 0 and `up_rdata` all zero, for reads and writes alike.
- R5: A secure-region access with `cfg_master_ns` = 1 and `cfg_err_resp` = 1 is not forwarded. The cycle after acceptance it is answered with `up_rsp_err` = 1.
- R6: An error-blocked access accepted while `irq_clr` = 0 sets `irq` in the next cycle. `irq` then stays high until cleared, across later accesses.
- R7: While `irq_clr` is high, `irq` is low from the next cycle on, and error-blocked accesses do not raise it.
- R8: While `rst_n` is low: `irq`, `dn_req_valid` and `up_rsp_valid` are 0, and `up_req_ready` is 1.
- R9: A forwarded request carries the accepted `up_addr`, `up_write`, `up_size` (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8) and `up_wdata` unchanged. The downstream `dn_rdata` and `dn_rsp_err` are returned upstream unchanged.
- R10: Once accepted, the action stays fixed: while a downstream request waits for ready, `dn_secure` and `dn_addr` hold even if the configuration inputs change.
- R11: Only one access is in flight. `up_req_ready` is low from the cycle after acceptance until the upstream response handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master_ns | input | 1 | Master is configured non-secure |
| cfg_err_resp | input | 1 | Blocked accesses get an error response (else read-as-zero/write-ignored) |
| irq_clr | input | 1 | Level clear and suppress for the violation interrupt |
| irq | output | 1 | Sticky violation interrupt |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_addr | input | AW | Request address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Access size code, log2 of byte count |
| up_wdata | input | DW | Write data, little-endian |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rdata | output | DW | Response read data |
| up_rsp_err | output | 1 | Response error flag |
| lkp_addr | output | AW | Address presented to the region lookup |
| lkp_exempt | input | 1 | Lookup: address is exempt from checking |
| lkp_ns | input | 1 | Lookup: address is in a non-secure region |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_addr | output | AW | Forwarded address |
| dn_write | output | 1 | Forwarded direction |
| dn_size | output | 2 | Forwarded size code |
| dn_wdata | output | DW | Forwarded write data |
| dn_secure | output | 1 | Security attribute, 1 = secure |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response ready |
| dn_rdata | input | DW | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error flag |

## Verification
The checker watches every cycle for the following:
- the mapping from lookup flags and configuration at acceptance to the resulting action and security attribute;
- the absence of a downstream request for blocked accesses;
- the set, hold and clear behaviour of the sticky interrupt;
- the stability of a stalled downstream request;
- the single-outstanding rule.

Some properties can only be shown by the bench scenarios. These are the exact values carried through:
- forwarded address, size and data;
- read data and error returned from downstream;
- zero data on masked reads;
- the reset values;
- configuration inputs toggled while a request is stalled;
- an upstream response held off by a stalled master.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {
    ACT_ABORT  = 2'd0,
    ACT_MASK   = 2'd1,
    ACT_FWD_S  = 2'd2,
    ACT_FWD_NS = 2'd3
  } sgate_act_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DN_REQ  = 2'd1,
    ST_DN_RSP  = 2'd2,
    ST_LOC_RSP = 2'd3
  } sgate_st_e;

  function automatic logic act_forwards(sgate_act_e a);
    return (a == ACT_FWD_S) || (a == ACT_FWD_NS);
  endfunction
endpackage

// File: rtl/sgate_decide.sv
module sgate_decide
  import sgate_pkg::*;
(
  input  logic       exempt_i,
  input  logic       ns_region_i,
  input  logic       master_ns_i,
  input  logic       err_sel_i,
  output sgate_act_e act_o
);
  always_comb begin
    if (exempt_i) begin
      act_o = master_ns_i ? ACT_FWD_NS : ACT_FWD_S;
    end else if (ns_region_i) begin
      act_o = ACT_FWD_NS;
    end else if (!master_ns_i) begin
      act_o = ACT_FWD_S;
    end else if (err_sel_i) begin
      act_o = ACT_ABORT;
    end else begin
      act_o = ACT_MASK;
    end
  end
endmodule

// File: rtl/sgate_irq.sv
module sgate_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic sts_q;
  logic sts_d;
  logic sts_en;

  // clear has priority over a same-cycle violation
  always_comb begin
    sts_en = clr_i | set_i;
    sts_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  assign irq_o = sts_q;
endmodule

// File: rtl/sgate_xfer.sv
module sgate_xfer
  import sgate_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sgate_act_e        act_i,
  output logic              accept_o,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [AW-1:0]     up_addr,
  input  logic              up_write,
  input  logic [SIZE_W-1:0] up_size,
  input  logic [DW-1:0]     up_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DW-1:0]     up_rdata,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [AW-1:0]     dn_addr,
  output logic              dn_write,
  output logic [SIZE_W-1:0] dn_size,
  output logic [DW-1:0]     dn_wdata,
  output logic              dn_secure,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DW-1:0]     dn_rdata,
  input  logic              dn_rsp_err
);
  sgate_st_e         state_q, state_d;
  sgate_act_e        act_q;
  logic [AW-1:0]     addr_q;
  logic              wr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DW-1:0]     wdata_q;
  logic              hold_en;

  assign up_req_ready = (state_q == ST_IDLE);
  assign accept_o     = up_req_valid && up_req_ready;
  assign hold_en      = accept_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          state_d = act_forwards(act_i) ? ST_DN_REQ : ST_LOC_RSP;
        end
      end
      ST_DN_REQ: begin
        if (dn_req_ready) state_d = ST_DN_RSP;
      end
      ST_DN_RSP: begin
        if (dn_rsp_valid && up_rsp_ready) state_d = ST_IDLE;
      end
      ST_LOC_RSP: begin
        if (up_rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= ACT_ABORT;
    end else begin
      state_q <= state_d;
      if (hold_en) act_q <= act_i;
    end
  end

  // payload holding registers: no reset, qualified by valid
  always_ff @(posedge clk) begin
    if (hold_en) begin
      addr_q  <= up_addr;
      wr_q    <= up_write;
      size_q  <= up_size;
      wdata_q <= up_wdata;
    end
  end

  always_comb begin
    dn_req_valid = (state_q == ST_DN_REQ);
    dn_addr      = addr_q;
    dn_write     = wr_q;
    dn_size      = size_q;
    dn_wdata     = wdata_q;
    dn_secure    = (act_q == ACT_FWD_S);
    dn_rsp_ready = (state_q == ST_DN_RSP) && up_rsp_ready;
    up_rsp_valid = ((state_q == ST_DN_RSP) && dn_rsp_valid) || (state_q == ST_LOC_RSP);
    up_rdata     = (state_q == ST_DN_RSP) ? dn_rdata : '0;
    up_rsp_err   = (state_q == ST_DN_RSP) ? dn_rsp_err
                 : ((state_q == ST_LOC_RSP) && (act_q == ACT_ABORT));
  end
endmodule

// File: rtl/bus_master_sec_gate.sv
module bus_master_sec_gate
  import sgate_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master_ns,
  input  logic              cfg_err_resp,
  input  logic              irq_clr,
  output logic              irq,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [AW-1:0]     up_addr,
  input  logic              up_write,
  input  logic [SIZE_W-1:0] up_size,
  input  logic [DW-1:0]     up_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DW-1:0]     up_rdata,
  output logic              up_rsp_err,
  output logic [AW-1:0]     lkp_addr,
  input  logic              lkp_exempt,
  input  logic              lkp_ns,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [AW-1:0]     dn_addr,
  output logic              dn_write,
  output logic [SIZE_W-1:0] dn_size,
  output logic [DW-1:0]     dn_wdata,
  output logic              dn_secure,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DW-1:0]     dn_rdata,
  input  logic              dn_rsp_err
);
  sgate_act_e act;
  logic       accept;
  logic       viol_set;

  assign lkp_addr = up_addr;

  sgate_decide u_decide (
    .exempt_i    (lkp_exempt),
    .ns_region_i (lkp_ns),
    .master_ns_i (cfg_master_ns),
    .err_sel_i   (cfg_err_resp),
    .act_o       (act)
  );

  sgate_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_i        (act),
    .accept_o     (accept),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_addr      (up_addr),
    .up_write     (up_write),
    .up_size      (up_size),
    .up_wdata     (up_wdata),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rdata     (up_rdata),
    .up_rsp_err   (up_rsp_err),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_addr      (dn_addr),
    .dn_write     (dn_write),
    .dn_size      (dn_size),
    .dn_wdata     (dn_wdata),
    .dn_secure    (dn_secure),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_ready (dn_rsp_ready),
    .dn_rdata     (dn_rdata),
    .dn_rsp_err   (dn_rsp_err)
  );

  assign viol_set = accept && (act == ACT_ABORT);

  sgate_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (viol_set),
    .clr_i (irq_clr),
    .irq_o (irq)
  );
endmodule

// File: rtl/sgate_chk.sv
module sgate_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_master_ns,
  input logic          cfg_err_resp,
  input logic          irq_clr,
  input logic          irq,
  input logic          up_req_valid,
  input logic          up_req_ready,
  input logic          up_rsp_valid,
  input logic [DW-1:0] up_rdata,
  input logic          up_rsp_err,
  input logic          lkp_exempt,
  input logic          lkp_ns,
  input logic          dn_req_valid,
  input logic          dn_req_ready,
  input logic [AW-1:0] dn_addr,
  input logic          dn_secure
);
  logic acc;
  logic sec_blk;
  assign acc     = up_req_valid && up_req_ready;
  assign sec_blk = acc && !lkp_exempt && !lkp_ns && cfg_master_ns;

  // R1
  exempt_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && lkp_exempt |=> dn_req_valid && (dn_secure == !$past(cfg_master_ns)));

  // R2
  ns_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lkp_exempt && lkp_ns |=> dn_req_valid && !dn_secure);

  // R3
  sec_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lkp_exempt && !lkp_ns && !cfg_master_ns |=> dn_req_valid && dn_secure);

  // R4
  mask_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_blk && !cfg_err_resp |=> up_rsp_valid && !up_rsp_err && (up_rdata == '0) && !dn_req_valid);

  // R5
  abort_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_blk && cfg_err_resp |=> up_rsp_valid && up_rsp_err && !dn_req_valid);

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_blk && cfg_err_resp && !irq_clr |=> irq);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_secure) && $stable(dn_addr));

  // R11
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !up_req_ready);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_rsp_valid && dn_req_valid));
endmodule

bind bus_master_sec_gate sgate_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_master_ns (cfg_master_ns),
  .cfg_err_resp  (cfg_err_resp),
  .irq_clr       (irq_clr),
  .irq           (irq),
  .up_req_valid  (up_req_valid),
  .up_req_ready  (up_req_ready),
  .up_rsp_valid  (up_rsp_valid),
  .up_rdata      (up_rdata),
  .up_rsp_err    (up_rsp_err),
  .lkp_exempt    (lkp_exempt),
  .lkp_ns        (lkp_ns),
  .dn_req_valid  (dn_req_valid),
  .dn_req_ready  (dn_req_ready),
  .dn_addr       (dn_addr),
  .dn_secure     (dn_secure)
);

// File: tb/tb_bus_master_sec_gate.sv
module tb_bus_master_sec_gate;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int NV = 12;
  // {exempt, ns_region, master_ns, err_resp, write, size[1:0], expect[1:0]}
  // expect: 0 error, 1 masked, 2 forward secure, 3 forward non-secure
  localparam logic [8:0] VEC [NV] = '{
    9'b1_0_0_0_0_11_10,  // R1 secure master
    9'b1_0_1_0_1_10_11,  // R1 ns master
    9'b1_1_1_1_0_01_11,  // R1 exempt wins
    9'b1_1_0_1_1_00_10,  // R1
    9'b0_1_0_0_0_10_11,  // R2
    9'b0_1_1_1_1_11_11,  // R2
    9'b0_0_0_0_1_01_10,  // R3
    9'b0_0_0_1_0_00_10,  // R3
    9'b0_0_1_0_0_11_01,  // R4 read
    9'b0_0_1_0_1_10_01,  // R4 write
    9'b0_0_1_1_0_10_00,  // R5 read
    9'b0_0_1_1_1_11_00   // R5 write
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_master_ns, cfg_err_resp, irq_clr, irq;
  logic          up_req_valid, up_req_ready, up_write;
  logic [AW-1:0] up_addr;
  logic [1:0]    up_size;
  logic [DW-1:0] up_wdata;
  logic          up_rsp_valid, up_rsp_ready, up_rsp_err;
  logic [DW-1:0] up_rdata;
  logic [AW-1:0] lkp_addr;
  logic          lkp_exempt, lkp_ns;
  logic          dn_req_valid, dn_req_ready, dn_write, dn_secure;
  logic [AW-1:0] dn_addr;
  logic [1:0]    dn_size;
  logic [DW-1:0] dn_wdata;
  logic          dn_rsp_valid, dn_rsp_ready, dn_rsp_err;
  logic [DW-1:0] dn_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_irq = 0;
  bit dn_err_inj = 0;

  always #2 clk = ~clk;

  bus_master_sec_gate #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_master_ns(cfg_master_ns), .cfg_err_resp(cfg_err_resp),
    .irq_clr(irq_clr), .irq(irq), .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_addr(up_addr), .up_write(up_write), .up_size(up_size), .up_wdata(up_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready), .up_rdata(up_rdata),
    .up_rsp_err(up_rsp_err), .lkp_addr(lkp_addr), .lkp_exempt(lkp_exempt), .lkp_ns(lkp_ns),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_secure(dn_secure),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready), .dn_rdata(dn_rdata),
    .dn_rsp_err(dn_rsp_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dn_model(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic run_txn(input logic ex, input logic ns, input logic cns, input logic cerr,
                         input logic wr, input logic [1:0] sz, input logic [1:0] exp,
                         input logic [AW-1:0] addr, input logic [DW-1:0] wd, input int stall);
    string req;
    req = ex ? "R1" : ns ? "R2" : !cns ? "R3" : cerr ? "R5" : "R4";
    @(negedge clk);
    cfg_master_ns = cns; cfg_err_resp = cerr;
    lkp_exempt = ex; lkp_ns = ns;
    up_req_valid = 1'b1; up_addr = addr; up_write = wr; up_size = sz; up_wdata = wd;
    chk("R11 ready idle", up_req_ready, 1'b1);
    @(posedge clk); #1;
    up_req_valid = 1'b0; lkp_exempt = ~ex; lkp_ns = ~ns;
    if (exp >= 2'd2) begin
      chk({req, " fwd"}, dn_req_valid, 1'b1);
      chk({req, " attr"}, dn_secure, exp == 2'd2);
      chk("R9 addr", dn_addr, addr);
      chk("R9 size", dn_size, sz);
      chk("R9 write", dn_write, wr);
      chk("R9 wdata", dn_wdata, wd);
      chk("R11 busy", up_req_ready, 1'b0);
      @(posedge clk); #1;
      dn_rsp_valid = 1'b1; dn_rdata = dn_model(addr); dn_rsp_err = dn_err_inj;
      #1;
      chk("R9 rsp valid", up_rsp_valid, 1'b1);
      chk("R9 rdata", up_rdata, dn_model(addr));
      chk("R9 err", up_rsp_err, dn_err_inj);
      @(posedge clk); #1;
      dn_rsp_valid = 1'b0; dn_rsp_err = 1'b0;
    end else begin
      chk({req, " rsp valid"}, up_rsp_valid, 1'b1);
      chk({req, " err"}, up_rsp_err, exp == 2'd0);
      chk({req, " zero data"}, up_rdata, '0);
      chk({req, " not forwarded"}, dn_req_valid, 1'b0);
      if (exp == 2'd0 && !irq_clr) exp_irq = 1'b1;
      if (stall > 0) begin
        up_rsp_ready = 1'b0;
        for (int k = 0; k < stall; k++) begin
          @(posedge clk); #1;
          chk("R11 rsp held", up_rsp_valid, 1'b1);
          chk("R11 busy while held", up_req_ready, 1'b0);
        end
        up_rsp_ready = 1'b1;
      end
      @(posedge clk); #1;
      chk({req, " done"}, up_rsp_valid, 1'b0);
      chk({req, " still not forwarded"}, dn_req_valid, 1'b0);
    end
    chk("R11 idle again", up_req_ready, 1'b1);
    chk("R6 irq", irq, exp_irq);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_master_ns = 1'b0; cfg_err_resp = 1'b0; irq_clr = 1'b0;
    up_req_valid = 1'b0; up_addr = '0; up_write = 1'b0; up_size = 2'd0; up_wdata = '0;
    up_rsp_ready = 1'b1; lkp_exempt = 1'b0; lkp_ns = 1'b0;
    dn_req_ready = 1'b1; dn_rsp_valid = 1'b0; dn_rdata = '0; dn_rsp_err = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R8 reset values
    chk("R8 irq", irq, 1'b0);
    chk("R8 dn valid", dn_req_valid, 1'b0);
    chk("R8 rsp valid", up_rsp_valid, 1'b0);
    chk("R8 ready", up_req_ready, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:2], VEC[i][1:0],
              32'h1000_0000 + i * 32'h44, {32'hC0DE_0000 + i, 32'hA5A5_5A5A}, (i == 8) ? 2 : 0);
    end

    // R7 clear drops the pending interrupt
    @(negedge clk); irq_clr = 1'b1;
    @(posedge clk); #1;
    exp_irq = 1'b0;
    chk("R7 cleared", irq, 1'b0);
    // R7 violation while clear is held does not raise it
    run_txn(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 32'h2000_0010, '0, 0);
    chk("R7 suppressed", irq, 1'b0);
    @(negedge clk); irq_clr = 1'b0;
    // R6 raised again, then sticky across a forwarded access
    run_txn(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 2'd0, 32'h2000_0020, 64'h1, 0);
    run_txn(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 32'h2000_0030, '0, 0);
    chk("R6 sticky", irq, 1'b1);

    // R9 downstream error passes through
    dn_err_inj = 1'b1;
    run_txn(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd2, 32'h3000_0008, '0, 0);
    dn_err_inj = 1'b0;

    // R10 action fixed while downstream stalls
    @(negedge clk);
    dn_req_ready = 1'b0; cfg_master_ns = 1'b0; cfg_err_resp = 1'b0;
    lkp_exempt = 1'b0; lkp_ns = 1'b0;
    up_req_valid = 1'b1; up_addr = 32'h4000_0100; up_write = 1'b1; up_size = 2'd2;
    up_wdata = 64'hDEAD_BEEF_0123_4567;
    @(posedge clk); #1;
    up_req_valid = 1'b0; cfg_master_ns = 1'b1; cfg_err_resp = 1'b1; up_addr = 32'h0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 still requesting", dn_req_valid, 1'b1);
      chk("R10 attr held", dn_secure, 1'b1);
      chk("R10 addr held", dn_addr, 32'h4000_0100);
    end
    dn_req_ready = 1'b1;
    @(posedge clk); #1;
    dn_rsp_valid = 1'b1; dn_rdata = '0;
    #1;
    chk("R10 completes", up_rsp_valid, 1'b1);
    @(posedge clk); #1;
    dn_rsp_valid = 1'b0; cfg_master_ns = 1'b0; cfg_err_resp = 1'b0;

    // R8 reset in the middle of operation clears the interrupt
    chk("R8 pre-reset irq", irq, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 irq after reset", irq, 1'b0);
    chk("R8 ready after reset", up_req_ready, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    exp_irq = 1'b0;
    run_txn(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 32'h5000_0001, '0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule